// File: doc/BRIEF.md
# Calendar Clock with Rate-Selected Periodic Interrupt

This block keeps wall-clock time (seconds, minutes, hours, weekday, date, month and two-digit year) in a small register file. Software reaches every register through two steps: it first writes an index, then it reads or writes the data at that index. A 15-bit prescaler counts a 32.768 kHz enable pulse. It advances the calendar once per second and also produces a programmable periodic event.

Three event sources are collected in a flag register that clears when it is read: the periodic event, an alarm match on hour, minute and second, and the end of each calendar update. The interrupt request output is high while any flag is set whose enable bit is also set. Two control registers choose the divider state and the periodic rate, halting of updates, the interrupt enables, binary or BCD storage, and 12-hour or 24-hour hours. A status bit warns software that an update is close.

Top module: `rtc_core`

## Requirements
- R1: A write strobe on `idx_we_i` loads the index. A data write strobe stores `wdata_i` at that index. A read strobe returns the indexed register on `rdata_o` at the next clock edge, and `rdata_o` holds between reads. Index 00h is seconds, 01h seconds alarm, 02h minutes, 03h minutes alarm, 04h hours, 05h hours alarm, 06h weekday, 07h date, 08h month and 09h year. Indices 0Eh and above read 00h. After reset the time reads 00:00:00, weekday, date and month read 01h, and control A reads 20h and control B 02h.
- R2: While control A bits 6-4 equal 010, each cycle with `tick_i` high advances the prescaler. Every 32768th tick advances the seconds. Cycles with `tick_i` low count nothing.
- R3: The update carries seconds into minutes at 60, minutes into hours at 60, and hours into date and weekday at 24. The weekday runs 1 to 7. The date wraps after the last day of the month, which is 28 days for February, or 29 when the year is a multiple of 4, 30 for April, June, September and November, and 31 otherwise. The month wraps from 12 to 1 and bumps the year, which wraps from 99 to 0.
- R4: Control B bit 2 set stores every time and alarm byte in binary. Cleared, the bytes are packed BCD.
- R5: Control B bit 1 cleared selects 12-hour hours: bit 7 of the hour byte means PM and the low bits run 12, 1, ..., 11, so 11:59:59 PM steps to 12:00:00 AM. Set, the hours run 0 to 23.
- R6: Control A bit 7 reads 1 during the last 8 prescaler ticks before each update and 0 otherwise. It reads 0 while updates are halted. It cannot be written.
- R7: Divider value 110 or 111 holds the prescaler at zero, so after returning to 010 the first update comes a full 32768 ticks later. Any value other than 010 stops counting.
- R8: Control B bit 7 set halts updates: the time bytes stay unchanged and no update flag is raised.
- R9: With control A bits 3-0 equal to r and r not zero, the periodic flag is set every 2^(r-1) ticks counted from prescaler zero (r=3 gives 4 ticks, r=15 gives 16384 ticks). With r=0 no periodic flag is raised.
- R10: Each update sets the update flag. It also sets the alarm flag when the new second, minute and hour bytes equal the three alarm bytes.
- R11: Register 0Ch reads {IRQF, periodic, alarm, update, 0000}. IRQF is high when any flag is set whose enable bit is set (control B bit 6 periodic, bit 5 alarm, bit 4 update). A read of 0Ch clears the three flags. `irq_o` equals IRQF.
- R12: Register 0Dh always reads 80h. Writes to 0Ch and 0Dh have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz count enable |
| idx_we_i | input | 1 | Load the index from `wdata_i` |
| data_we_i | input | 1 | Write `wdata_i` to the indexed register |
| data_rd_i | input | 1 | Read the indexed register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Interrupt request |

## Verification
A prescaler that is off by one tick shows up right away as an update-in-progress bit that flips one read too early or too late. It also moves the periodic interrupt off the 4-tick and 16384-tick points, where the bench compares `irq_o` every cycle. A wrong carry in the calendar stays hidden until a rollover second. For that reason the bench loads 23:59:58 on 31 December 99 and 11:59:59 PM on 28 February of a non-leap year, then checks every byte after one update. Flags that clear wrongly, or are raised by a halted clock, show up at the very next read of 0Ch.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_TIME = 10;
  localparam int IDX_SEC  = 0;
  localparam int IDX_ASEC = 1;
  localparam int IDX_MIN  = 2;
  localparam int IDX_AMIN = 3;
  localparam int IDX_HR   = 4;
  localparam int IDX_AHR  = 5;
  localparam int IDX_DOW  = 6;
  localparam int IDX_DOM  = 7;
  localparam int IDX_MON  = 8;
  localparam int IDX_YR   = 9;
  localparam logic [7:0] REG_A = 8'h0A;
  localparam logic [7:0] REG_B = 8'h0B;
  localparam logic [7:0] REG_C = 8'h0C;
  localparam logic [7:0] REG_D = 8'h0D;

  function automatic logic [7:0] from_reg(input logic [7:0] v, input logic bin);
    logic [7:0] t;
    t = {4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]};
    return bin ? v : t;
  endfunction

  function automatic logic [7:0] to_reg(input logic [7:0] v, input logic bin);
    logic [7:0] tens, ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return bin ? v : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] hr_to24(input logic [7:0] v, input logic bin, input logic h24);
    logic [7:0] h;
    if (h24) return from_reg(v, bin);
    h = from_reg({1'b0, v[6:0]}, bin);
    if (h == 8'd12) h = 8'd0;
    if (v[7]) h = h + 8'd12;
    return h;
  endfunction

  function automatic logic [7:0] hr_from24(input logic [7:0] h, input logic bin, input logic h24);
    logic [7:0] h12, e;
    if (h24) return to_reg(h, bin);
    h12 = h % 8'd12;
    if (h12 == 8'd0) h12 = 8'd12;
    e = to_reg(h12, bin);
    return {(h >= 8'd12), e[6:0]};
  endfunction

  function automatic logic [7:0] days_in(input logic [7:0] mo, input logic [7:0] yr);
    case (mo)
      8'd2:                         return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:      return 8'd30;
      default:                      return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int unsigned DIV_W     = 15,
  parameter int unsigned UIP_TICKS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [2:0] div_sel_i,
  input  logic [3:0] rate_i,
  input  logic       halt_i,
  output logic       sec_step_o,
  output logic       per_pulse_o,
  output logic       uip_o
);
  localparam logic [DIV_W-1:0] CNT_MAX   = '1;
  localparam logic [DIV_W-1:0] UIP_START = CNT_MAX - DIV_W'(UIP_TICKS - 1);

  logic [DIV_W-1:0] cnt_q, rate_mask;
  logic run, hold;

  assign run  = (div_sel_i == 3'b010);
  assign hold = (div_sel_i[2:1] == 2'b11);

  // period 2^(rate-1): pulse when the low rate-1 bits are all ones
  always_comb begin
    rate_mask = '0;
    for (int i = 0; i < int'(DIV_W); i++)
      if (i < int'(rate_i) - 1) rate_mask[i] = 1'b1;
  end

  assign per_pulse_o = tick_i && run && (rate_i != 4'd0) && ((cnt_q & rate_mask) == rate_mask);
  assign sec_step_o  = tick_i && run && !halt_i && (cnt_q == CNT_MAX);
  assign uip_o       = run && !halt_i && (cnt_q >= UIP_START);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (hold)           cnt_q <= '0;
    else if (tick_i && run)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [3:0]               widx_i,
  input  logic [7:0]               wdata_i,
  input  logic                     step_i,
  input  logic                     bin_i,
  input  logic                     h24_i,
  output logic [NUM_TIME-1:0][7:0] regs_o,
  output logic                     alarm_o
);
  logic [NUM_TIME-1:0][7:0] regs_q, nxt;
  logic [7:0] s, m, h, dw, dm, mo, y;

  always_comb begin
    s  = from_reg(regs_q[IDX_SEC], bin_i) + 8'd1;
    m  = from_reg(regs_q[IDX_MIN], bin_i);
    h  = hr_to24(regs_q[IDX_HR], bin_i, h24_i);
    dw = from_reg(regs_q[IDX_DOW], bin_i);
    dm = from_reg(regs_q[IDX_DOM], bin_i);
    mo = from_reg(regs_q[IDX_MON], bin_i);
    y  = from_reg(regs_q[IDX_YR], bin_i);
    if (s >= 8'd60) begin
      s = 8'd0;
      m = m + 8'd1;
      if (m >= 8'd60) begin
        m = 8'd0;
        h = h + 8'd1;
        if (h >= 8'd24) begin
          h  = 8'd0;
          dw = (dw >= 8'd7 || dw == 8'd0) ? 8'd1 : dw + 8'd1;
          dm = dm + 8'd1;
          if (dm > days_in(mo, y)) begin
            dm = 8'd1;
            mo = mo + 8'd1;
            if (mo > 8'd12) begin
              mo = 8'd1;
              y  = (y >= 8'd99) ? 8'd0 : y + 8'd1;
            end
          end
        end
      end
    end
    nxt          = regs_q;
    nxt[IDX_SEC] = to_reg(s, bin_i);
    nxt[IDX_MIN] = to_reg(m, bin_i);
    nxt[IDX_HR]  = hr_from24(h, bin_i, h24_i);
    nxt[IDX_DOW] = to_reg(dw, bin_i);
    nxt[IDX_DOM] = to_reg(dm, bin_i);
    nxt[IDX_MON] = to_reg(mo, bin_i);
    nxt[IDX_YR]  = to_reg(y, bin_i);
    alarm_o = step_i && !we_i
              && (nxt[IDX_SEC] == regs_q[IDX_ASEC])
              && (nxt[IDX_MIN] == regs_q[IDX_AMIN])
              && (nxt[IDX_HR]  == regs_q[IDX_AHR]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q          <= '0;
      regs_q[IDX_DOW] <= 8'h01;
      regs_q[IDX_DOM] <= 8'h01;
      regs_q[IDX_MON] <= 8'h01;
    end else if (we_i) begin
      // a host write wins over a coincident update
      for (int i = 0; i < NUM_TIME; i++)
        if (widx_i == 4'(i)) regs_q[i] <= wdata_i;
    end else if (step_i) begin
      regs_q <= nxt;
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       per_i,
  input  logic       alm_i,
  input  logic       upd_i,
  input  logic       clr_i,
  input  logic [2:0] en_i,
  output logic [2:0] flags_o,
  output logic       irqf_o
);
  logic [2:0] flags_q;

  // new events win over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (clr_i ? 3'b000 : flags_q) | {per_i, alm_i, upd_i};
  end

  assign flags_o = flags_q;
  assign irqf_o  = |(flags_q & en_i);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned DIV_W     = 15,
  parameter int unsigned UIP_TICKS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       idx_we_i,
  input  logic       data_we_i,
  input  logic       data_rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  logic [7:0] index_q, reg_b_q, rd_val;
  logic [6:0] reg_a_q;
  logic [NUM_TIME-1:0][7:0] time_regs;
  logic [2:0] flags;
  logic sec_step, per_pulse, uip, alarm_hit, irqf, time_we, rd_c;

  assign time_we = data_we_i && (index_q < 8'(NUM_TIME));
  assign rd_c    = data_rd_i && (index_q == REG_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      reg_a_q <= 7'h20;
      reg_b_q <= 8'h02;
    end else begin
      if (idx_we_i) index_q <= wdata_i;
      if (data_we_i && index_q == REG_A) reg_a_q <= wdata_i[6:0];
      if (data_we_i && index_q == REG_B) reg_b_q <= wdata_i;
    end
  end

  rtc_divider #(.DIV_W(DIV_W), .UIP_TICKS(UIP_TICKS)) u_div (
    .clk_i, .rst_ni, .tick_i,
    .div_sel_i  (reg_a_q[6:4]),
    .rate_i     (reg_a_q[3:0]),
    .halt_i     (reg_b_q[7]),
    .sec_step_o (sec_step),
    .per_pulse_o(per_pulse),
    .uip_o      (uip)
  );

  rtc_calendar u_cal (
    .clk_i, .rst_ni,
    .we_i   (time_we),
    .widx_i (index_q[3:0]),
    .wdata_i,
    .step_i (sec_step),
    .bin_i  (reg_b_q[2]),
    .h24_i  (reg_b_q[1]),
    .regs_o (time_regs),
    .alarm_o(alarm_hit)
  );

  rtc_flags u_flags (
    .clk_i, .rst_ni,
    .per_i  (per_pulse),
    .alm_i  (alarm_hit),
    .upd_i  (sec_step),
    .clr_i  (rd_c),
    .en_i   (reg_b_q[6:4]),
    .flags_o(flags),
    .irqf_o (irqf)
  );

  always_comb begin
    rd_val = 8'h00;
    for (int i = 0; i < NUM_TIME; i++)
      if (index_q == 8'(i)) rd_val = time_regs[i];
    case (index_q)
      REG_A:   rd_val = {uip, reg_a_q};
      REG_B:   rd_val = reg_b_q;
      REG_C:   rd_val = {irqf, flags, 4'h0};
      REG_D:   rd_val = 8'h80;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (data_rd_i) rdata_o <= rd_val;
  end

  assign irq_o = irqf;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       data_rd_i,
  input logic       data_we_i,
  input logic [7:0] index_i,
  input logic [7:0] rdata_i,
  input logic       irq_i,
  input logic [6:0] reg_a_i,
  input logic [7:0] reg_b_i,
  input logic       uip_i,
  input logic       sec_step_i,
  input logic       per_pulse_i,
  input logic [7:0] sec_byte_i
);
  p_rdata_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_rd_i |=> $stable(rdata_i));

  p_step_in_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_step_i |-> uip_i);

  p_halt_no_uip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_b_i[7] |-> !uip_i);

  p_hold_no_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_a_i[6:5] == 2'b11) |-> !sec_step_i);

  p_halt_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_b_i[7] && !data_we_i) |=> $stable(sec_byte_i));

  p_read_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && index_i == 8'h0C && !per_pulse_i && !sec_step_i) |=> !irq_i);

  p_no_enable_no_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_b_i[6:4] == 3'b000) |-> !irq_i);
endmodule

bind rtc_core rtc_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .data_rd_i  (data_rd_i),
  .data_we_i  (data_we_i),
  .index_i    (index_q),
  .rdata_i    (rdata_o),
  .irq_i      (irq_o),
  .reg_a_i    (reg_a_q),
  .reg_b_i    (reg_b_q),
  .uip_i      (uip),
  .sec_step_i (sec_step),
  .per_pulse_i(per_pulse),
  .sec_byte_i (time_regs[0])
);

// File: tb/rtc_core_test.sv
`timescale 1ns/1ps
module rtc_core_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, idx_we = 1'b0, dat_we = 1'b0, dat_rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_core uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .idx_we_i(idx_we),
    .data_we_i(dat_we), .data_rd_i(dat_rd), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural model
  int m_idx, m_sec, m_min, m_hr, m_dow, m_dom, m_mon, m_yr, m_presc, m_a, m_b, m_rd;
  int m_al[3];
  bit m_pf, m_af, m_uf;

  function automatic int enc(int v);
    return (m_b & 4) ? v : (v / 10) * 16 + v % 10;
  endfunction
  function automatic int dec(int v);
    return (m_b & 4) ? v : (v >> 4) * 10 + (v & 15);
  endfunction
  function automatic int enc_hr(int h);
    int h12;
    if (m_b & 2) return enc(h);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    return enc(h12) | ((h >= 12) ? 128 : 0);
  endfunction
  function automatic int dec_hr(int v);
    int h;
    if (m_b & 2) return dec(v);
    h = dec(v & 127);
    if (h == 12) h = 0;
    if (v & 128) h += 12;
    return h;
  endfunction
  function automatic int mlen(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic bit m_uip();
    return ((m_a >> 4) & 7) == 2 && !(m_b & 128) && m_presc >= 32760;
  endfunction
  function automatic bit m_irq();
    return (m_pf && (m_b & 64)) || (m_af && (m_b & 32)) || (m_uf && (m_b & 16));
  endfunction
  function automatic int m_read(int i);
    case (i)
      0: return enc(m_sec);   1: return m_al[0];
      2: return enc(m_min);   3: return m_al[1];
      4: return enc_hr(m_hr); 5: return m_al[2];
      6: return enc(m_dow);   7: return enc(m_dom);
      8: return enc(m_mon);   9: return enc(m_yr);
      10: return (m_uip() ? 128 : 0) | m_a;
      11: return m_b;
      12: return (m_irq() ? 128 : 0) | (m_pf ? 64 : 0) | (m_af ? 32 : 0) | (m_uf ? 16 : 0);
      13: return 128;
      default: return 0;
    endcase
  endfunction

  task automatic m_write(int i, int v);
    case (i)
      0: m_sec = dec(v);   1: m_al[0] = v;
      2: m_min = dec(v);   3: m_al[1] = v;
      4: m_hr = dec_hr(v); 5: m_al[2] = v;
      6: m_dow = dec(v);   7: m_dom = dec(v);
      8: m_mon = dec(v);   9: m_yr = dec(v);
      10: begin m_a = v & 127; if (((m_a >> 5) & 3) == 3) m_presc = 0; end
      11: m_b = v;
      default: ;
    endcase
  endtask

  task automatic m_tick();
    int rate;
    rate = m_a & 15;
    if (((m_a >> 4) & 7) != 2) return;
    if (rate != 0 && ((m_presc + 1) % (1 << (rate - 1))) == 0) m_pf = 1;
    m_presc = (m_presc + 1) % 32768;
    if (m_presc == 0 && !(m_b & 128)) begin
      m_sec++;
      if (m_sec == 60) begin
        m_sec = 0; m_min++;
        if (m_min == 60) begin
          m_min = 0; m_hr++;
          if (m_hr == 24) begin
            m_hr = 0;
            m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
            m_dom++;
            if (m_dom > mlen(m_mon, m_yr)) begin
              m_dom = 1; m_mon++;
              if (m_mon > 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
            end
          end
        end
      end
      m_uf = 1;
      if (enc(m_sec) == m_al[0] && enc(m_min) == m_al[1] && enc_hr(m_hr) == m_al[2]) m_af = 1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_dom = 1; m_mon = 1; m_yr = 0;
      m_al[0] = 0; m_al[1] = 0; m_al[2] = 0; m_a = 'h20; m_b = 'h02; m_presc = 0; m_rd = 0;
      m_pf = 0; m_af = 0; m_uf = 0;
    end else begin
      if (dat_rd) begin
        m_rd = m_read(m_idx);
        if (m_idx == 12) begin m_pf = 0; m_af = 0; m_uf = 0; end
      end
      if (dat_we) m_write(m_idx, wdata);
      if (idx_we) m_idx = wdata;
      if (tick) m_tick();
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 irq_o vs model", {31'd0, irq}, {31'd0, m_irq()});
      chk("R1 rdata_o vs model", {24'd0, rdata}, m_rd);
    end
  end

  task automatic put_idx(input logic [7:0] v);
    idx_we = 1; wdata = v; @(negedge clk); idx_we = 0;
  endtask
  task automatic put(input logic [7:0] i, input logic [7:0] v);
    put_idx(i); dat_we = 1; wdata = v; @(negedge clk); dat_we = 0;
  endtask
  task automatic get(input logic [7:0] i, output logic [7:0] v);
    put_idx(i); dat_rd = 1; @(negedge clk); dat_rd = 0; v = rdata;
  endtask
  task automatic expect_reg(input string tag, input logic [7:0] i, input logic [7:0] e);
    logic [7:0] v;
    get(i, v);
    chk(tag, {24'd0, v}, {24'd0, e});
  endtask
  task automatic run(input int n);
    tick = 1; repeat (n) @(negedge clk); tick = 0;
  endtask
  task automatic run_gap(input int n);
    repeat (n) begin tick = 1; @(negedge clk); tick = 0; @(negedge clk); end
  endtask
  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    expect_reg("R1 reset seconds", 8'h00, 8'h00);
    expect_reg("R1 reset weekday", 8'h06, 8'h01);
    expect_reg("R1 reset ctrl A", 8'h0A, 8'h20);
    expect_reg("R1 reset ctrl B", 8'h0B, 8'h02);
    expect_reg("R11 reset flags", 8'h0C, 8'h00);
    expect_reg("R1 unused index", 8'h20, 8'h00);
    // read-only registers
    put(8'h0C, 8'hFF); put(8'h0D, 8'h00);
    expect_reg("R12 flags write ignored", 8'h0C, 8'h00);
    expect_reg("R12 power status", 8'h0D, 8'h80);
    put(8'h0A, 8'hA0);
    expect_reg("R6 uip not writable", 8'h0A, 8'h20);

    // BCD 24h year rollover with alarm at midnight
    put(8'h0A, 8'h70);
    put(8'h00, 8'h58); put(8'h02, 8'h59); put(8'h04, 8'h23);
    put(8'h06, 8'h07); put(8'h07, 8'h31); put(8'h08, 8'h12); put(8'h09, 8'h99);
    put(8'h01, 8'h00); put(8'h03, 8'h00); put(8'h05, 8'h00);
    put(8'h0A, 8'h20);
    run(32759);
    expect_reg("R6 uip low before window", 8'h0A, 8'h20);
    run(1);
    expect_reg("R6 uip high in window", 8'h0A, 8'hA0);
    run(8);
    expect_reg("R2 seconds after 32768 ticks", 8'h00, 8'h59);
    expect_reg("R10 update flag only", 8'h0C, 8'h10);
    expect_reg("R11 flags cleared by read", 8'h0C, 8'h00);
    run(32768);
    expect_reg("R3 seconds wrap", 8'h00, 8'h00);
    expect_reg("R3 hour wrap", 8'h04, 8'h00);
    expect_reg("R3 weekday wrap", 8'h06, 8'h01);
    expect_reg("R3 date wrap", 8'h07, 8'h01);
    expect_reg("R3 month wrap", 8'h08, 8'h01);
    expect_reg("R4 year wrap bcd", 8'h09, 8'h00);
    expect_reg("R10 alarm and update", 8'h0C, 8'h30);

    // binary 12h, non-leap February, divider hold then restart
    put(8'h0B, 8'h14);
    put(8'h0A, 8'h70);
    put(8'h00, 8'd59); put(8'h02, 8'd59); put(8'h04, 8'h8B);
    put(8'h06, 8'd3); put(8'h07, 8'd28); put(8'h08, 8'd2); put(8'h09, 8'd3);
    run(500);
    put(8'h0A, 8'h20);
    run(32767);
    expect_reg("R7 no update before full second", 8'h00, 8'd59);
    run(1);
    expect_reg("R5 pm 11 to am 12", 8'h04, 8'h0C);
    expect_reg("R4 binary minutes", 8'h02, 8'h00);
    expect_reg("R3 february to march date", 8'h07, 8'h01);
    expect_reg("R3 february to march month", 8'h08, 8'h03);
    expect_reg("R3 weekday step", 8'h06, 8'h04);
    chk("R11 irq with update enable", {31'd0, irq}, 32'd1);
    expect_reg("R11 irqf and update flag", 8'h0C, 8'h90);
    chk("R11 irq after clear", {31'd0, irq}, 32'd0);

    // halt
    put(8'h0B, 8'h94);
    run(32765);
    expect_reg("R6 uip low while halted", 8'h0A, 8'h20);
    run(3);
    expect_reg("R8 seconds frozen", 8'h00, 8'h00);
    expect_reg("R8 no update flag", 8'h0C, 8'h00);

    // periodic
    put(8'h0B, 8'h40);
    put(8'h0A, 8'h70); put(8'h0A, 8'h23);
    run_gap(3);
    chk("R9 no periodic before 4 ticks", {31'd0, irq}, 32'd0);
    run_gap(1);
    chk("R9 periodic after 4 ticks", {31'd0, irq}, 32'd1);
    expect_reg("R11 periodic flag", 8'h0C, 8'hC0);
    put(8'h0A, 8'h70); put(8'h0A, 8'h20);
    run(100);
    chk("R9 rate zero silent", {31'd0, irq}, 32'd0);
    put(8'h0A, 8'h70); put(8'h0A, 8'h2F);
    run(16383);
    chk("R9 rate 15 before period", {31'd0, irq}, 32'd0);
    run(1);
    chk("R9 rate 15 at 16384 ticks", {31'd0, irq}, 32'd1);
    expect_reg("R11 periodic flag rate 15", 8'h0C, 8'hC0);
    repeat (2) @(negedge clk);
    report();
  end
endmodule